// File: doc/BRIEF.md
# SSI Absolute Position Reader

This block is the clock-owning side of a Synchronous Serial Interface link to an absolute position encoder. While `en` is high it runs acquisition frames one after another. Each frame pulls the serial clock low to make the encoder latch its position. It then clocks the position word in, most significant bit first. An even parity bit is checked when it is enabled. The serial clock is then held high for a programmable recovery time, the monoflop time, before the result is presented. At the end of that wait a good word appears on `pos` with a one-cycle `pos_valid` strobe, ready to be loaded as the count value of a downstream counter. A frame that fails parity raises a one-cycle `par_err` strobe instead and leaves `pos` as it was.

The output is a flow without back-pressure. `pos_valid` is a single-cycle strobe, and the consumer has to take the word in that cycle. `pos` holds its value until the next good frame, so a consumer may also read it later. Strobes are at least one full frame apart. Configuration is taken at the start of each frame and has no effect on a frame already running.

Top module: `ssi_master`

## Requirements
- R1: After reset `sclk` is 1, `pos` is 0, and `pos_valid` and `par_err` are 0.
- R2: Every low half-period of `sclk` lasts `cfg_div` system clock cycles; a `cfg_div` of 0 counts as 1. High half-periods have the same length.
- R3: A frame consists of exactly L + P + 1 `sclk` periods, each a low half followed by a high half. L is the effective length: `cfg_len` clamped to 1..MAX_LEN, where 0 counts as 1. P is 1 when `cfg_par_en` is set and 0 otherwise. The first period carries no data.
- R4: `sdi` is sampled as `sclk` rises in periods 1..L, most significant bit first. The word is right-aligned on `pos`, and the bits above L are 0.
- R5: With parity enabled, `sdi` sampled in period L+1 is the parity bit. The frame is good when that bit equals the XOR of the L data bits (even parity overall). A bad frame pulses `par_err` for one cycle, gives no `pos_valid`, and leaves `pos` unchanged.
- R6: With parity disabled, no parity period occurs and `par_err` never rises.
- R7: After the last high half, `sclk` stays high for `cfg_mono` cycles, where 0 counts as 1. Then the result strobe, either `pos_valid` or `par_err`, is raised for exactly one cycle.
- R8: With `en` held high, the next frame's falling `sclk` edge comes in the same cycle as the strobe. Strobes are therefore 2·(L+P+1)·D + M cycles apart. From the cycle in which `en` is first seen high, the first strobe comes 1 + 2·(L+P+1)·D + M cycles later.
- R9: When `en` falls during a frame, that frame still completes and gives its strobe. After that `sclk` stays high and no further strobe appears.
- R10: `cfg_len`, `cfg_par_en`, `cfg_div` and `cfg_mono` are captured when a frame starts. Changing them during a frame does not alter that frame's length, timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run frames while high |
| cfg_len | input | LEN_W (6) | Data bits per frame, clamped to 1..MAX_LEN |
| cfg_par_en | input | 1 | Expect and check an even parity bit |
| cfg_div | input | CNT_W (16) | System cycles per `sclk` half-period |
| cfg_mono | input | CNT_W (16) | Recovery time in system cycles |
| sdi | input | 1 | Serial data from the encoder |
| sclk | output | 1 | Serial clock to the encoder, idle high |
| pos | output | POS_W (32) | Last good position, unsigned |
| pos_valid | output | 1 | One-cycle strobe for a new position |
| par_err | output | 1 | One-cycle strobe for a frame failing parity |

## Verification
Random words are driven through frames with random lengths, divides, recovery times and parity settings. An encoder model shifts each word out on the falling `sclk` edges. Comparing bit order and masking catches an off-by-one in the sampled period. Timing every low half and every strobe interval catches errors in the divider and in the recovery count. Directed runs cover the clamped lengths (0 and above MAX_LEN), zero divide and zero recovery, all at the smallest and largest widths. Deliberately corrupted parity bits show whether `pos` is correctly held back. Each run ends by dropping `en` in the middle of a frame while also changing the configuration. This separates a design that finishes the frame cleanly from one that stops early, runs on, or picks up the new settings.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_MONO = 2'd3
  } ssi_state_e;
endpackage

// File: rtl/ssi_divider.sv
// Counts the cycles of one sclk half or of the recovery wait; tick marks the last one.
module ssi_divider #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = !hold && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (hold || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssi_rx_shift.sv
// Shift register for the data bits plus a running parity and the captured parity bit.
module ssi_rx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         cap_par,
  input  logic         sdi,
  output logic [W-1:0] word,
  output logic         data_par,
  output logic         par_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      word     <= '0;
      data_par <= 1'b0;
      par_bit  <= 1'b0;
    end else begin
      if (shift_en) begin
        word     <= {word[W-2:0], sdi};
        data_par <= data_par ^ sdi;
      end
      if (cap_par) par_bit <= sdi;
    end
  end
endmodule

// File: rtl/ssi_master.sv
module ssi_master #(
  parameter int MAX_LEN = 32,
  parameter int POS_W   = 32,
  parameter int CNT_W   = 16,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN + 3)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_par_en,
  input  logic [CNT_W-1:0] cfg_div,
  input  logic [CNT_W-1:0] cfg_mono,
  input  logic             sdi,
  output logic             sclk,
  output logic [POS_W-1:0] pos,
  output logic             pos_valid,
  output logic             par_err
);
  import ssi_pkg::*;

  ssi_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] lat_len_q;
  logic             lat_par_q;
  logic [CNT_W-1:0] lat_div_q, lat_mono_q;
  logic             start, commit, tick, last_period;
  logic             sample, shift_en, cap_par, par_ok;
  logic [IDX_W-1:0] len_clamp, frame_last;
  logic [CNT_W-1:0] limit;
  logic [MAX_LEN-1:0] word;
  logic             data_par, par_bit;

  // configuration clamp, applied when a frame starts
  always_comb begin
    if (cfg_len == '0)                       len_clamp = IDX_W'(1);
    else if (cfg_len > LEN_W'(MAX_LEN))      len_clamp = IDX_W'(MAX_LEN);
    else                                     len_clamp = IDX_W'(cfg_len);
  end

  assign frame_last  = lat_len_q + IDX_W'(lat_par_q);
  assign last_period = (idx_q == frame_last);
  assign limit       = (state_q == ST_MONO) ? lat_mono_q : lat_div_q;

  ssi_divider #(.CNT_W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (state_q == ST_IDLE),
    .limit (limit),
    .tick  (tick)
  );

  // frame sequencer
  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    commit  = 1'b0;
    case (state_q)
      ST_IDLE: if (en) begin
        state_d = ST_LOW;
        start   = 1'b1;
      end
      ST_LOW:  if (tick) state_d = ST_HIGH;
      ST_HIGH: if (tick) state_d = last_period ? ST_MONO : ST_LOW;
      ST_MONO: if (tick) begin
        commit = 1'b1;
        if (en) begin
          state_d = ST_LOW;
          start   = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign sample   = (state_q == ST_LOW) && tick && (idx_q != '0);
  assign shift_en = sample && (idx_q <= lat_len_q);
  assign cap_par  = sample && (idx_q > lat_len_q);
  assign par_ok   = !lat_par_q || (data_par == par_bit);

  ssi_rx_shift #(.W(MAX_LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .shift_en (shift_en),
    .cap_par  (cap_par),
    .sdi      (sdi),
    .word     (word),
    .data_par (data_par),
    .par_bit  (par_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      lat_len_q  <= IDX_W'(1);
      lat_par_q  <= 1'b0;
      lat_div_q  <= CNT_W'(1);
      lat_mono_q <= CNT_W'(1);
      sclk       <= 1'b1;
      pos        <= '0;
      pos_valid  <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sclk      <= (state_d != ST_LOW);
      pos_valid <= commit && par_ok;
      par_err   <= commit && !par_ok;
      if (commit && par_ok) pos <= POS_W'(word);
      if (start) begin
        idx_q      <= '0;
        lat_len_q  <= len_clamp;
        lat_par_q  <= cfg_par_en;
        lat_div_q  <= (cfg_div  == '0) ? CNT_W'(1) : cfg_div;
        lat_mono_q <= (cfg_mono == '0) ? CNT_W'(1) : cfg_mono;
      end else if (state_q == ST_HIGH && tick && !last_period) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssi_master_chk.sv
module ssi_master_chk #(
  parameter int POS_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sclk,
  input logic [POS_W-1:0]    pos,
  input logic                pos_valid,
  input logic                par_err,
  input ssi_pkg::ssi_state_e state,
  input logic                lat_par
);
  import ssi_pkg::*;

  // R5: a frame yields one kind of strobe, never both
  p_one_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_valid && par_err));

  // R5: the position moves only together with a valid strobe
  p_pos_moves_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> pos_valid);

  // R7: strobes last a single cycle
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid |=> !pos_valid);

  // R7: the result follows a recovery stretch with sclk high
  p_result_after_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid || par_err) |-> $past(sclk));

  // R6: no parity error from a frame captured without parity
  p_no_err_without_par_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> lat_par);

  // R9: sclk rests high whenever no frame runs
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> sclk);
endmodule

bind ssi_master ssi_master_chk #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .pos       (pos),
  .pos_valid (pos_valid),
  .par_err   (par_err),
  .state     (state_q),
  .lat_par   (lat_par_q)
);

// File: tb/ssi_master_tb.sv
`timescale 1ns/1ps
module ssi_master_tb;
  localparam int MAX_LEN = 32;
  localparam int POS_W   = 32;
  localparam int CNT_W   = 16;
  localparam int LEN_W   = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic             cfg_par_en = 1'b0;
  logic [CNT_W-1:0] cfg_div = '0;
  logic [CNT_W-1:0] cfg_mono = '0;
  logic             sdi = 1'b0;
  logic             sclk;
  logic [POS_W-1:0] pos;
  logic             pos_valid;
  logic             par_err;

  ssi_master #(.MAX_LEN(MAX_LEN), .POS_W(POS_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_div(cfg_div), .cfg_mono(cfg_mono), .sdi(sdi), .sclk(sclk),
    .pos(pos), .pos_valid(pos_valid), .par_err(par_err)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  // run configuration seen by the encoder model and the monitor
  int e_len, e_par, e_n, e_div, e_mq;
  logic [31:0] words [16];
  bit          bad   [16];
  int fidx, efr;
  logic [31:0] cur;

  // monitor state
  bit  mon_on = 1'b0;
  int  ev_fr, falls, low_run, last_ev_cyc;
  bit  prev_sclk, vchk_pend, stopped, low_after;
  logic [31:0] last_good;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int eff_len(input int l);
    if (l == 0) return 1;
    if (l > MAX_LEN) return MAX_LEN;
    return l;
  endfunction

  function automatic logic [31:0] len_mask(input int l);
    if (l >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << l) - 32'h1;
  endfunction

  // encoder model: presents the next bit on every falling sclk edge
  always @(negedge sclk) begin
    if (fidx == 0) cur = words[efr];
    if (fidx >= 1 && fidx <= e_len) sdi = cur[e_len - fidx];
    else if (fidx == e_len + 1)     sdi = (^cur) ^ bad[efr];
    else                            sdi = 1'b0;
    fidx++;
    if (fidx == e_n) begin
      fidx = 0;
      efr++;
    end
  end

  // monitor, sampling between clock edges
  always @(negedge clk) begin
    if (mon_on) begin
      bit fell_now;
      fell_now = prev_sclk && !sclk;
      if (fell_now) falls++;
      if (vchk_pend) begin
        chk(!pos_valid && !par_err, "R7 strobe width", {pos_valid, par_err}, 0);
        vchk_pend = 1'b0;
      end
      if (!sclk) low_run++;
      else if (low_run != 0) begin
        chk(low_run == e_div, "R2 low half", low_run, e_div);
        low_run = 0;
      end
      if (stopped && !sclk) low_after = 1'b1;
      if (pos_valid || par_err) begin
        int exp_gap;
        exp_gap = 2 * e_n * e_div + e_mq + ((ev_fr == 0) ? 1 : 0);
        chk((cyc - last_ev_cyc) == exp_gap, "R7 R8 strobe spacing", cyc - last_ev_cyc, exp_gap);
        chk((falls - int'(fell_now)) == e_n, "R3 periods per frame", falls - int'(fell_now), e_n);
        falls = int'(fell_now);
        if (ev_fr < 16) begin
          if (bad[ev_fr]) begin
            chk(par_err && !pos_valid, "R5 error strobe", {pos_valid, par_err}, 1);
            chk(pos == last_good, "R5 position held", pos, last_good);
          end else begin
            chk(pos_valid && !par_err, e_par ? "R5 good frame" : "R6 no parity", {pos_valid, par_err}, 2);
            chk(pos == words[ev_fr], "R4 position", pos, words[ev_fr]);
            last_good = words[ev_fr];
          end
        end
        vchk_pend = 1'b1;
        ev_fr++;
        last_ev_cyc = cyc;
      end
      prev_sclk = sclk;
    end
  end

  task automatic run_case(input int len_cfg, input int par, input int div, input int mono,
                          input int nfr, input bit allow_bad);
    e_len = eff_len(len_cfg);
    e_par = par;
    e_n   = e_len + par + 1;
    e_div = (div == 0) ? 1 : div;
    e_mq  = (mono == 0) ? 1 : mono;
    for (int i = 0; i < 16; i++) begin
      words[i] = $urandom & len_mask(e_len);
      bad[i]   = (par != 0) && allow_bad && ($urandom % 3 == 0);
    end
    @(negedge clk);
    mon_on     = 1'b0;
    en         = 1'b0;
    cfg_len    = LEN_W'(len_cfg);
    cfg_par_en = (par != 0);
    cfg_div    = CNT_W'(div);
    cfg_mono   = CNT_W'(mono);
    rst_n      = 1'b0;
    fidx = 0; efr = 0; ev_fr = 0; falls = 0; low_run = 0;
    vchk_pend = 1'b0; stopped = 1'b0; low_after = 1'b0; last_good = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1, "R1 sclk idle", sclk, 1);
    chk(pos == '0, "R1 pos", pos, 0);
    chk(!pos_valid && !par_err, "R1 strobes", {pos_valid, par_err}, 0);
    prev_sclk   = sclk;
    mon_on      = 1'b1;
    en          = 1'b1;
    last_ev_cyc = cyc;
    wait (ev_fr == nfr - 1);
    wait (sclk == 1'b0);
    // last frame running: drop enable and disturb the configuration (R9, R10)
    en         = 1'b0;
    cfg_len    = LEN_W'($urandom);
    cfg_par_en = ~cfg_par_en;
    cfg_div    = CNT_W'($urandom % 7);
    cfg_mono   = CNT_W'($urandom % 50);
    wait (ev_fr == nfr);
    stopped = 1'b1;
    repeat (2 * e_n * e_div + e_mq + 40) @(negedge clk);
    chk(!low_after, "R9 sclk stays high", low_after, 0);
    chk(ev_fr == nfr, "R9 strobe count", ev_fr, nfr);
    chk(sclk == 1'b1, "R9 idle level", sclk, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // directed corners
    run_case(1,  1, 0, 0, 6, 1'b1);   // shortest frame, zero divide and recovery
    run_case(32, 1, 1, 5, 6, 1'b1);   // full width with parity
    run_case(40, 0, 2, 3, 4, 1'b0);   // length above range clamps to 32
    run_case(0,  0, 1, 2, 4, 1'b0);   // zero length counts as one bit
    run_case(16, 1, 3, 20, 8, 1'b1);  // mid width, corrupted parity mixed in
    run_case(8,  0, 1, 1, 5, 1'b0);   // no parity, tight timing
    // constrained random
    for (int k = 0; k < 10; k++) begin
      run_case(1 + $urandom % 32, $urandom % 2, $urandom % 5, $urandom % 41,
               4 + $urandom % 5, 1'b1);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 190000) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end
endmodule